// File: doc/BRIEF.md
# Unified Memory Port Arbiter

This block lets a five-stage in-order pipeline (IF, ID, EX, MEM, WB) run from one single-port memory that holds both code and data. Every cycle it gives the single port either to the instruction in the MEM stage or to the instruction fetch. Only loads and stores need the port in MEM. An arithmetic instruction that reaches MEM leaves the fetch alone, so the front end runs at full rate.

When a load or store holds MEM, the data access takes the port, and this fixed priority lets the older instruction always make progress. In the same cycle the block tells the front end to hold its PC and IF/ID register, and to send a bubble into decode. EX, MEM and WB keep advancing. Each memory instruction therefore costs one extra front-end cycle. The memory reads synchronously, with a latency set by a parameter (one cycle by default). The block records which requester owned each read and sends the returned word either to the fetch path or to the load path. A request with both the load and store bits set is treated as a store.

Top module: `shared_port_arb`

## Requirements
- R1: When the MEM-stage request is valid and marked load or store, `fe_stall` and `id_bubble` are 1 in that same cycle. In every other cycle, including a valid request with neither bit set (an ALU instruction), both are 0.
- R2: In a data-access cycle, `port_addr` equals `mem_addr`. In every other cycle it equals `fe_addr`.
- R3: `port_we` is 1 only in a cycle where the MEM-stage request is valid and marked store. A fetch never raises it.
- R4: In a store cycle, `port_wdata` equals `mem_wdata`.
- R5: A granted fetch returns `port_rdata` on `fe_rdata` with `fe_rvalid`=1, RD_LAT cycles after the grant. A load returns the word on `mem_rdata` with `mem_rvalid`=1 in the same way. A store, an idle cycle (`fe_req`=0 and no data access) and a stalled fetch produce no response. At most one valid is 1 in any cycle.
- R6: Over any instruction stream, the number of cycles with `fe_stall`=1 equals the number of valid load and store requests.
- R7: While `mem_valid`=0, the `mem_load` and `mem_store` bits have no effect. There is no stall, the fetch address drives the port, and the fetch returns its word.
- R8: After reset, `fe_rvalid` and `mem_rvalid` are 0, and with idle inputs `fe_stall` is 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_req | input | 1 | Fetch stage wants an instruction word |
| fe_addr | input | AW | PC address of the fetch |
| mem_valid | input | 1 | MEM stage holds a valid instruction |
| mem_load | input | 1 | That instruction is a load |
| mem_store | input | 1 | That instruction is a store |
| mem_addr | input | AW | Data address |
| mem_wdata | input | DW | Store data |
| port_addr | output | AW | Memory port address |
| port_we | output | 1 | Memory port write enable |
| port_wdata | output | DW | Memory port write data |
| port_rdata | input | DW | Memory port read data, RD_LAT cycles after the address |
| fe_stall | output | 1 | Hold PC and IF/ID register this cycle |
| id_bubble | output | 1 | Feed a bubble into decode this cycle |
| fe_rdata | output | DW | Fetched instruction word |
| fe_rvalid | output | 1 | `fe_rdata` is valid |
| mem_rdata | output | DW | Load data |
| mem_rvalid | output | 1 | `mem_rdata` is valid |

## Verification
The bench targets a store followed at once by a load from the same address. A design that drove the write enable late, or dropped the store, would return stale data to the load. It also uses back-to-back loads and alternating load and fetch cycles. If the owner tracking were off by a cycle, fetch words would reach the load path or the other way round. It also drives ALU instructions in MEM and requests with the load bit set while `mem_valid` is low. A design that decoded too broadly would stall there and lose fetch throughput, which the stall-count comparison exposes. Idle cycles and store cycles must produce no response, so a design that flagged read data on every cycle would leave surplus items against the scoreboard.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Who owns the word coming back from the memory port
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_FETCH = 2'd1,
    OWN_LOAD  = 2'd2
  } owner_e;

endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/arb_grant.sv
module arb_grant
  import arb_pkg::*;
(
  input  logic   fe_req,
  input  logic   mem_valid,
  input  logic   mem_load,
  input  logic   mem_store,
  output logic   grant_data,
  output logic   grant_fetch,
  output logic   is_write,
  output owner_e issue_owner
);

  logic mem_op;

  always_comb begin
    // Only loads and stores touch the port in MEM
    mem_op      = mem_valid & (mem_load | mem_store);
    grant_data  = mem_op;
    grant_fetch = fe_req & ~mem_op;
    is_write    = mem_op & mem_store;
    if (mem_op && !mem_store)   issue_owner = OWN_LOAD;
    else if (grant_fetch)       issue_owner = OWN_FETCH;
    else                        issue_owner = OWN_NONE;
  end

endmodule

// File: rtl/arb_port_drive.sv
module arb_port_drive #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          grant_data,
  input  logic          is_write,
  input  logic [AW-1:0] fe_addr,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] port_addr,
  output logic          port_we,
  output logic [DW-1:0] port_wdata
);

  always_comb begin
    port_addr  = grant_data ? mem_addr : fe_addr;
    port_we    = is_write;
    port_wdata = is_write ? mem_wdata : '0;
  end

endmodule

// File: rtl/arb_rsp_steer.sv
module arb_rsp_steer
  import arb_pkg::*;
#(
  parameter int DW     = 32,
  parameter int RD_LAT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  owner_e        issue_owner,
  input  logic [DW-1:0] port_rdata,
  output logic [DW-1:0] fe_rdata,
  output logic          fe_rvalid,
  output logic [DW-1:0] mem_rdata,
  output logic          mem_rvalid
);

  owner_e pipe_q [RD_LAT];
  owner_e pipe_d [RD_LAT];
  owner_e ret_owner;

  generate
    for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_comb pipe_d[s] = issue_owner;
      end else begin : g_tail
        always_comb pipe_d[s] = pipe_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= OWN_NONE;
        else        pipe_q[s] <= pipe_d[s];
      end
    end
  endgenerate

  assign ret_owner = pipe_q[RD_LAT-1];

  always_comb begin
    fe_rvalid  = (ret_owner == OWN_FETCH);
    mem_rvalid = (ret_owner == OWN_LOAD);
    fe_rdata   = fe_rvalid  ? port_rdata : '0;
    mem_rdata  = mem_rvalid ? port_rdata : '0;
  end

endmodule

// File: rtl/shared_port_arb.sv
module shared_port_arb
  import arb_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int RD_LAT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fe_req,
  input  logic [AW-1:0] fe_addr,
  input  logic          mem_valid,
  input  logic          mem_load,
  input  logic          mem_store,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] port_addr,
  output logic          port_we,
  output logic [DW-1:0] port_wdata,
  input  logic [DW-1:0] port_rdata,
  output logic          fe_stall,
  output logic          id_bubble,
  output logic [DW-1:0] fe_rdata,
  output logic          fe_rvalid,
  output logic [DW-1:0] mem_rdata,
  output logic          mem_rvalid
);

  logic   rst_q;
  logic   grant_data;
  logic   grant_fetch;
  logic   is_write;
  owner_e issue_owner;

  arb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q)
  );

  arb_grant u_grant (
    .fe_req      (fe_req),
    .mem_valid   (mem_valid),
    .mem_load    (mem_load),
    .mem_store   (mem_store),
    .grant_data  (grant_data),
    .grant_fetch (grant_fetch),
    .is_write    (is_write),
    .issue_owner (issue_owner)
  );

  arb_port_drive #(.AW(AW), .DW(DW)) u_drive (
    .grant_data (grant_data),
    .is_write   (is_write),
    .fe_addr    (fe_addr),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .port_addr  (port_addr),
    .port_we    (port_we),
    .port_wdata (port_wdata)
  );

  arb_rsp_steer #(.DW(DW), .RD_LAT(RD_LAT)) u_steer (
    .clk         (clk),
    .rst_n       (rst_q),
    .issue_owner (issue_owner),
    .port_rdata  (port_rdata),
    .fe_rdata    (fe_rdata),
    .fe_rvalid   (fe_rvalid),
    .mem_rdata   (mem_rdata),
    .mem_rvalid  (mem_rvalid)
  );

  // Front end holds PC and IF/ID and decode takes a bubble while data owns the port
  always_comb begin
    fe_stall  = grant_data;
    id_bubble = grant_data;
  end

  logic unused_grant;
  assign unused_grant = grant_fetch;

endmodule

// File: rtl/shared_port_arb_chk.sv
module shared_port_arb_chk #(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int RD_LAT = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fe_req,
  input logic [AW-1:0] fe_addr,
  input logic          mem_valid,
  input logic          mem_load,
  input logic          mem_store,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [AW-1:0] port_addr,
  input logic          port_we,
  input logic [DW-1:0] port_wdata,
  input logic          fe_stall,
  input logic          id_bubble,
  input logic          fe_rvalid,
  input logic          mem_rvalid
);

  logic [RD_LAT-1:0] ld_pipe;
  logic [RD_LAT-1:0] fe_pipe;
  logic              ld_now;
  logic              fe_now;

  assign ld_now = mem_valid & mem_load & ~mem_store;
  assign fe_now = fe_req & ~(mem_valid & (mem_load | mem_store));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_pipe <= '0;
      fe_pipe <= '0;
    end else begin
      ld_pipe[0] <= ld_now;
      fe_pipe[0] <= fe_now;
      for (int i = 1; i < RD_LAT; i++) begin
        ld_pipe[i] <= ld_pipe[i-1];
        fe_pipe[i] <= fe_pipe[i-1];
      end
    end
  end

  a_r1_stall_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && (mem_load || mem_store)) |-> (fe_stall && id_bubble));

  a_r1_no_stall_alu: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_valid || (!mem_load && !mem_store)) |-> (!fe_stall && !id_bubble));

  a_r2_data_addr: assert property (@(posedge clk) disable iff (!rst_n)
    fe_stall |-> (port_addr == mem_addr));

  a_r2_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !fe_stall |-> (port_addr == fe_addr));

  a_r3_we_only_store: assert property (@(posedge clk) disable iff (!rst_n)
    port_we |-> (mem_valid && mem_store && fe_stall));

  a_r4_wdata: assert property (@(posedge clk) disable iff (!rst_n)
    port_we |-> (port_wdata == mem_wdata));

  a_r5_one_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !(fe_rvalid && mem_rvalid));

  a_r5_load_resp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid == ld_pipe[RD_LAT-1]);

  a_r5_fetch_resp: assert property (@(posedge clk) disable iff (!rst_n)
    fe_rvalid == fe_pipe[RD_LAT-1]);

endmodule

bind shared_port_arb shared_port_arb_chk #(.AW(AW), .DW(DW), .RD_LAT(RD_LAT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .fe_req     (fe_req),
  .fe_addr    (fe_addr),
  .mem_valid  (mem_valid),
  .mem_load   (mem_load),
  .mem_store  (mem_store),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .port_addr  (port_addr),
  .port_we    (port_we),
  .port_wdata (port_wdata),
  .fe_stall   (fe_stall),
  .id_bubble  (id_bubble),
  .fe_rvalid  (fe_rvalid),
  .mem_rvalid (mem_rvalid)
);

// File: tb/shared_port_arb_test.sv
`timescale 1ns/1ps
module shared_port_arb_test;

  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          fe_req;
  logic [AW-1:0] fe_addr;
  logic          mem_valid, mem_load, mem_store;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [AW-1:0] port_addr;
  logic          port_we;
  logic [DW-1:0] port_wdata;
  logic [DW-1:0] port_rdata;
  logic          fe_stall, id_bubble;
  logic [DW-1:0] fe_rdata, mem_rdata;
  logic          fe_rvalid, mem_rvalid;

  shared_port_arb #(.AW(AW), .DW(DW), .RD_LAT(1)) uut (
    .clk(clk), .rst_n(rst_n), .fe_req(fe_req), .fe_addr(fe_addr),
    .mem_valid(mem_valid), .mem_load(mem_load), .mem_store(mem_store),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .port_addr(port_addr),
    .port_we(port_we), .port_wdata(port_wdata), .port_rdata(port_rdata),
    .fe_stall(fe_stall), .id_bubble(id_bubble), .fe_rdata(fe_rdata),
    .fe_rvalid(fe_rvalid), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int ops_issued = 0;
  int stalls_seen = 0;
  bit done = 0;

  // Memory model: one-cycle synchronous read, write at the edge
  logic [DW-1:0] mem_model [256];
  logic [DW-1:0] ref_mem   [256];
  always @(posedge clk) begin
    if (port_we) mem_model[port_addr[7:0]] <= port_wdata;
    port_rdata <= mem_model[port_addr[7:0]];
  end

  // Scoreboard items: kind 1 = load response, 0 = fetch response
  typedef struct { bit kind; logic [DW-1:0] data; } item_t;
  item_t exp_q [$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit f, input logic [AW-1:0] fa, input bit v, input bit ld,
                      input bit st, input logic [AW-1:0] ma, input logic [DW-1:0] wd);
    bit acc;
    item_t it;
    @(negedge clk);
    fe_req = f; fe_addr = fa; mem_valid = v; mem_load = ld; mem_store = st;
    mem_addr = ma; mem_wdata = wd;
    #1;
    acc = v && (ld || st);
    if (acc) ops_issued++;
    if (fe_stall) stalls_seen++;
    check(fe_stall == acc, "R1 fe_stall", 64'(fe_stall), 64'(acc));
    check(id_bubble == acc, "R1 id_bubble", 64'(id_bubble), 64'(acc));
    check(port_addr == (acc ? ma : fa), "R2 port_addr", 64'(port_addr), 64'(acc ? ma : fa));
    check(port_we == (v && st), "R3 port_we", 64'(port_we), 64'(v && st));
    if (v && st) check(port_wdata == wd, "R4 port_wdata", 64'(port_wdata), 64'(wd));
    if (acc && ld && !st) begin
      it.kind = 1'b1; it.data = ref_mem[ma[7:0]]; exp_q.push_back(it);
    end else if (!acc && f) begin
      it.kind = 1'b0; it.data = ref_mem[fa[7:0]]; exp_q.push_back(it);
    end
    if (v && st) ref_mem[ma[7:0]] = wd;
  endtask

  // Monitor: compare responses against the scoreboard (R5)
  always @(posedge clk) begin
    #2;
    if (rst_n && (fe_rvalid || mem_rvalid)) begin
      if (fe_rvalid && mem_rvalid) check(1'b0, "R5 both valid", 64'd3, 64'd1);
      else if (exp_q.size() == 0) check(1'b0, "R5 unexpected response", 64'(mem_rvalid), 64'd0);
      else begin
        item_t it;
        it = exp_q.pop_front();
        check(mem_rvalid == it.kind, "R5 response path", 64'(mem_rvalid), 64'(it.kind));
        check((it.kind ? mem_rdata : fe_rdata) == it.data, "R5 response data",
              64'(it.kind ? mem_rdata : fe_rdata), 64'(it.data));
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      check(1'b0, "watchdog expired", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 256; i++) begin
      mem_model[i] = 32'h9E37_79B9 * (i + 1);
      ref_mem[i]   = 32'h9E37_79B9 * (i + 1);
    end
    rst_n = 1'b0; fe_req = 0; fe_addr = '0; mem_valid = 0; mem_load = 0;
    mem_store = 0; mem_addr = '0; mem_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    check(fe_rvalid == 0 && mem_rvalid == 0, "R8 reset valids", 64'({fe_rvalid, mem_rvalid}), 64'd0);
    check(fe_stall == 0, "R8 reset stall", 64'(fe_stall), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(fe_rvalid == 0 && mem_rvalid == 0, "R8 idle valids", 64'({fe_rvalid, mem_rvalid}), 64'd0);

    // Straight ALU stream: fetch every cycle, ALU in MEM (R1, R5)
    for (int i = 0; i < 6; i++) step(1, 16'(i), 1, 0, 0, 16'h00F0, 32'h0);
    // Single load, then single store (R1-R5)
    step(1, 16'd10, 1, 1, 0, 16'd40, 32'h0);
    step(1, 16'd11, 1, 0, 1, 16'd41, 32'hDEAD_BEEF);
    // Store then load the same address (R3, R4, R5)
    step(1, 16'd12, 1, 0, 1, 16'd50, 32'h1234_5678);
    step(1, 16'd12, 1, 1, 0, 16'd50, 32'h0);
    step(1, 16'd12, 0, 0, 0, 16'd0, 32'h0);
    // Back-to-back loads
    for (int i = 0; i < 4; i++) step(1, 16'd13, 1, 1, 0, 16'(60 + i), 32'h0);
    // Bits set while MEM stage invalid are ignored (R7)
    step(1, 16'd20, 0, 1, 0, 16'd70, 32'h0);
    step(1, 16'd21, 0, 0, 1, 16'd71, 32'hFFFF_FFFF);
    step(1, 16'd22, 0, 0, 0, 16'd71, 32'h0);
    step(1, 16'd22, 1, 1, 0, 16'd71, 32'h0);
    // Idle front end, no access: no response (R5)
    step(0, 16'd30, 0, 0, 0, 16'd0, 32'h0);
    step(0, 16'd30, 1, 0, 0, 16'd0, 32'h0);
    // Store with fetch idle
    step(0, 16'd31, 1, 0, 1, 16'd80, 32'hCAFE_0001);
    step(1, 16'd80, 0, 0, 0, 16'd0, 32'h0);
    // Mixed pseudo-random stream (R6)
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], {8'h00, lfsr[15:8]}, lfsr[1], lfsr[2] & ~lfsr[3],
           lfsr[3] & lfsr[4], {8'h00, lfsr[11:4]}, {lfsr, ~lfsr});
    end
    step(0, 16'd0, 0, 0, 0, 16'd0, 32'h0);
    step(0, 16'd0, 0, 0, 0, 16'd0, 32'h0);
    repeat (2) @(negedge clk);
    check(stalls_seen == ops_issued, "R6 stall count", 64'(stalls_seen), 64'(ops_issued));
    check(exp_q.size() == 0, "R5 missing responses", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule